// File: doc/BRIEF.md
# Marker-Bit Nibble Entry Register

This block is the entry stage of a four-bit-wide first-in first-out buffer. It collects one nibble from an upstream source, either all four bits at once or one bit at a time, and holds that nibble until the downstream stack takes it. While the word is held, the block refuses new data. Once the stack accepts the word, the block can collect the next one.

Completion is detected without a bit counter. A five-stage chain is reset with a single marker bit in its topmost data stage. Each serial shift moves the marker one stage down, toward a fifth flag stage. The word is complete when the marker reaches the flag stage, and the four bits received then sit in the data stages. A parallel load fills the data stages and sets the flag stage directly.

The design is synchronous to one system clock. The serial clock is treated as an ordinary asynchronous input: it is passed through two synchroniser flops, and its falling edge is detected from the synchronised copy.

A small controller decides which operation the chain performs each cycle. It has three states:
- `ST_IDLE`: the chain holds the reset pattern.
- `ST_ASSEMBLE`: some serial bits are in.
- `ST_FULL`: the word is complete.

Its transitions are:
- IDLE→FULL on a parallel load.
- IDLE→ASSEMBLE on a serial shift that does not complete the word.
- ASSEMBLE→FULL on a parallel load, or on the shift that moves the marker into the flag stage.
- FULL→IDLE on a stack accept.

Top module: `marker_entry_reg`

## Requirements
- R1: After reset, `full_n` is 1, `xfer_req` is 0, and `xfer_word` is 4'b1000. This is the marker in bit 3 with the other data bits clear.
- R2: When `pload` is 1 in a cycle while the register is not full, the next cycle shows `xfer_word` equal to that cycle's `pdata`, with `full_n` at 0.
- R3: Each falling edge of `sclk` seen while `sen_n` is 0 and the register is not full shifts `sdata` into the chain. The first bit received ends in `xfer_word[0]` and the fourth in `xfer_word[3]`.
- R4: `full_n` stays 1 after three accepted serial edges and goes to 0 after exactly the fourth.
- R5: Falling edges of `sclk` while `sen_n` is 1 change neither `xfer_word` nor `full_n`.
- R6: While the register is full, serial edges leave `xfer_word` and `full_n` unchanged.
- R7: While the register is full, `pload` leaves `xfer_word` unchanged.
- R8: `xfer_req` is 1 exactly while `full_n` is 0. An `xfer_ack` pulse while full restores the reset pattern of R1 in the next cycle. An `xfer_ack` while not full has no effect.
- R9: If a parallel load and a detected serial falling edge fall in the same cycle, the load wins. `xfer_word` becomes `pdata` and the serial bit is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| pload | input | 1 | Parallel load request, active high |
| pdata | input | 4 | Parallel nibble |
| sdata | input | 1 | Serial data bit |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sen_n | input | 1 | Serial enable, active low |
| full_n | output | 1 | Register full flag, active low |
| xfer_req | output | 1 | Transfer request toward the stack |
| xfer_word | output | 4 | Held nibble (data stages of the chain) |
| xfer_ack | input | 1 | One-cycle accept pulse from the stack |

## Verification
The assertions rely on four assumptions about the inputs:
- `sdata` and `sen_n` are stable from the moment `sclk` falls until the resulting shift is taken.
- `xfer_ack` is a single-cycle pulse.
- `pload` is normally kept low during serial entry.
- The serial clock is slow enough that each level lasts several system cycles.

The stimulus holds each `sclk` level for at least three system cycles and changes `sdata` only while `sclk` is high. It breaks the load/serial exclusivity exactly once, on purpose, and times that break so the load lands in the same cycle as the detected serial edge.

// File: rtl/mer_pkg.sv
package mer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ASSEMBLE = 2'd1,
        ST_FULL     = 2'd2
    } mer_state_e;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2,
        OP_CLEAR = 2'd3
    } mer_op_e;

endpackage

// File: rtl/mer_edge_sync.sv
module mer_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic fall_o
);
    // STAGES synchroniser flops plus one history flop for edge detection
    localparam int LEN = STAGES + 1;

    logic [LEN-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[LEN-2:0], async_i};
    end

    assign fall_o = sh_q[LEN-1] & ~sh_q[LEN-2];

    // A detected falling edge never lasts more than one cycle
    AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o); // R3

endmodule

// File: rtl/mer_marker_chain.sv
module mer_marker_chain
    import mer_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  mer_op_e      op_i,
    input  logic [W-1:0] pdata_i,
    input  logic         sdata_i,
    output logic [W-1:0] word_o,
    output logic         fc_o,
    output logic         f0_o
);
    // Chain layout: bits W-1..0 are the data stages (bit 0 first out),
    // bit W is the flag stage. The marker is preset in the top data stage.
    localparam int                 LEN       = W + 1;
    localparam logic [LEN-1:0]     RESET_PAT = LEN'(1) << (W - 1);

    logic [LEN-1:0] chain_q;
    logic [LEN-1:0] chain_d;

    // Per-stage next value for the data stages
    for (genvar i = 0; i < W; i++) begin : g_stage
        logic upper;
        if (i == W - 1) begin : g_top
            assign upper = sdata_i;
        end else begin : g_mid
            assign upper = chain_q[i+1];
        end
        always_comb begin
            unique case (op_i)
                OP_LOAD:  chain_d[i] = pdata_i[i];
                OP_SHIFT: chain_d[i] = upper;
                OP_CLEAR: chain_d[i] = RESET_PAT[i];
                default:  chain_d[i] = chain_q[i];
            endcase
        end
    end

    // Flag stage next value
    always_comb begin
        unique case (op_i)
            OP_LOAD:  chain_d[W] = 1'b1;
            OP_SHIFT: chain_d[W] = chain_q[0];
            OP_CLEAR: chain_d[W] = 1'b0;
            default:  chain_d[W] = chain_q[W];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RESET_PAT;
        else        chain_q <= chain_d;
    end

    assign word_o = chain_q[W-1:0];
    assign fc_o   = chain_q[W];
    assign f0_o   = chain_q[0];

    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_LOAD) |=> (word_o == $past(pdata_i)) && fc_o); // R2

    AST_SHIFT_ENTERS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SHIFT) |=> (word_o[W-1] == $past(sdata_i))); // R3

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_o && op_i != OP_CLEAR) |=> $stable(word_o) && fc_o); // R6

    AST_CLEAR_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CLEAR) |=> ({fc_o, word_o} == RESET_PAT)); // R8

endmodule

// File: rtl/mer_ctrl.sv
module mer_ctrl
    import mer_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    pload_i,
    input  logic    fall_i,
    input  logic    sen_n_i,
    input  logic    ack_i,
    input  logic    fc_i,
    input  logic    f0_i,
    output mer_op_e op_o
);
    mer_state_e state_q;
    mer_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output process: operation requested from the chain
    always_comb begin
        op_o = OP_HOLD;
        unique case (state_q)
            ST_IDLE, ST_ASSEMBLE: begin
                if (pload_i)                 op_o = OP_LOAD;
                else if (fall_i && !sen_n_i) op_o = OP_SHIFT;
            end
            ST_FULL: begin
                if (ack_i) op_o = OP_CLEAR;
            end
            default: op_o = OP_HOLD;
        endcase
    end

    // Next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_ASSEMBLE: begin
                if (op_o == OP_LOAD)
                    state_d = ST_FULL;
                else if (op_o == OP_SHIFT)
                    // The marker is in F0 exactly when this shift completes the word
                    state_d = f0_i ? ST_FULL : ST_ASSEMBLE;
            end
            ST_FULL: begin
                if (op_o == OP_CLEAR) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // The controller's view of fullness must match the marker in the flag stage
    AST_STATE_TRACKS_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL) == fc_i); // R4

    AST_NO_SHIFT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        sen_n_i |-> (op_o != OP_SHIFT)); // R5

endmodule

// File: rtl/marker_entry_reg.sv
module marker_entry_reg
    import mer_pkg::*;
#(
    parameter int W           = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pload,
    input  logic [W-1:0] pdata,
    input  logic         sdata,
    input  logic         sclk,
    input  logic         sen_n,
    output logic         full_n,
    output logic         xfer_req,
    output logic [W-1:0] xfer_word,
    input  logic         xfer_ack
);
    logic    sclk_fall;
    logic    fc;
    logic    f0;
    mer_op_e op;

    mer_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(sclk),
        .fall_o (sclk_fall)
    );

    mer_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .pload_i(pload),
        .fall_i (sclk_fall),
        .sen_n_i(sen_n),
        .ack_i  (xfer_ack),
        .fc_i   (fc),
        .f0_i   (f0),
        .op_o   (op)
    );

    mer_marker_chain #(.W(W)) u_chain (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_i   (op),
        .pdata_i(pdata),
        .sdata_i(sdata),
        .word_o (xfer_word),
        .fc_o   (fc),
        .f0_o   (f0)
    );

    assign full_n   = ~fc;
    assign xfer_req = fc;

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (pload && sclk_fall && full_n) |=> (xfer_word == $past(pdata)) && !full_n); // R9

    AST_ACK_IDLE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ack && full_n && !pload && !sclk_fall) |=> $stable(xfer_word) && full_n); // R8

endmodule

// File: tb/marker_entry_reg_tb_top.sv
module marker_entry_reg_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pload = 1'b0;
    logic [3:0] pdata = 4'h0;
    logic       sdata = 1'b0;
    logic       sclk = 1'b1;
    logic       sen_n = 1'b0;
    logic       xfer_ack = 1'b0;
    logic       full_n;
    logic       xfer_req;
    logic [3:0] xfer_word;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    logic [3:0] ref_q[$];

    always #10 clk = ~clk; // 50 MHz

    marker_entry_reg dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pload    (pload),
        .pdata    (pdata),
        .sdata    (sdata),
        .sclk     (sclk),
        .sen_n    (sen_n),
        .full_n   (full_n),
        .xfer_req (xfer_req),
        .xfer_word(xfer_word),
        .xfer_ack (xfer_ack)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One serial bit: sclk low long enough for sync + shift, then back high
    task automatic ser_bit(input logic b);
        @(negedge clk);
        sdata = b;
        sclk  = 1'b0;
        repeat (4) @(negedge clk);
        sclk = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic ser_word(input logic [3:0] v);
        for (int i = 0; i < 4; i++) ser_bit(v[i]);
    endtask

    task automatic par_load(input logic [3:0] v);
        @(negedge clk);
        pload = 1'b1;
        pdata = v;
        @(negedge clk);
        pload = 1'b0;
    endtask

    task automatic accept_word(input string req);
        logic [3:0] exp;
        exp = ref_q.pop_front();
        chk({req, " transferred word"}, xfer_word, exp);
        chk("R8 request while full", xfer_req, 1);
        @(negedge clk);
        xfer_ack = 1'b1;
        @(negedge clk);
        xfer_ack = 1'b0;
        chk("R8 word after accept", xfer_word, 4'b1000);
        chk("R8 full_n after accept", full_n, 1);
        chk("R8 request after accept", xfer_req, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset pattern
        chk("R1 full_n", full_n, 1);
        chk("R1 xfer_req", xfer_req, 0);
        chk("R1 word", xfer_word, 4'b1000);

        // R8: accept while empty has no effect
        xfer_ack = 1'b1;
        @(negedge clk);
        xfer_ack = 1'b0;
        @(negedge clk);
        chk("R8 idle accept word", xfer_word, 4'b1000);
        chk("R8 idle accept full_n", full_n, 1);

        // R2: sweep all parallel values
        for (int v = 0; v < 16; v++) begin
            par_load(4'(v));
            chk("R2 full_n after load", full_n, 0);
            ref_q.push_back(4'(v));
            accept_word("R2");
        end

        // R3/R4: sweep all serial values
        for (int v = 0; v < 16; v++) begin
            for (int i = 0; i < 3; i++) ser_bit(v[i]);
            chk("R4 not full after three edges", full_n, 1);
            ser_bit(v[3]);
            chk("R4 full after fourth edge", full_n, 0);
            ref_q.push_back(4'(v));
            accept_word("R3");
        end

        // R5: edges with enable high are ignored
        sen_n = 1'b1;
        ser_bit(1'b1);
        ser_bit(1'b1);
        chk("R5 word unchanged", xfer_word, 4'b1000);
        chk("R5 full_n unchanged", full_n, 1);
        sen_n = 1'b0;
        ser_word(4'b0110);
        ref_q.push_back(4'b0110);
        accept_word("R5");

        // R8: accept during assembly is ignored
        ser_bit(1'b1);
        ser_bit(1'b0);
        @(negedge clk);
        xfer_ack = 1'b1;
        @(negedge clk);
        xfer_ack = 1'b0;
        chk("R8 partial accept full_n", full_n, 1);
        ser_bit(1'b1);
        ser_bit(1'b1);
        ref_q.push_back(4'b1101);
        accept_word("R8");

        // R6/R7: inhibit while full
        par_load(4'hA);
        ser_word(4'h5);
        chk("R6 word held under serial edges", xfer_word, 4'hA);
        chk("R6 full_n held", full_n, 0);
        par_load(4'h3);
        chk("R7 word held under load", xfer_word, 4'hA);
        ref_q.push_back(4'hA);
        accept_word("R7");

        // R9: protocol violation, load coincides with detected serial edge
        @(negedge clk);
        sdata = 1'b1;
        sclk  = 1'b0;
        repeat (2) @(negedge clk);
        pload = 1'b1;
        pdata = 4'h6;
        @(negedge clk);
        pload = 1'b0;
        $display("note: deliberate load/serial collision applied");
        chk("R9 load wins word", xfer_word, 4'h6);
        chk("R9 full after collision", full_n, 0);
        sclk = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 word still loaded", xfer_word, 4'h6);
        ref_q.push_back(4'h6);
        accept_word("R9");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule